// File: doc/BRIEF.md
# Conversion-Slot Trigger and Pending Tracker

This block sits in front of an ADC conversion sequencer and records which of its conversion slots have received a start request that has not yet been served. Each slot picks its trigger from one of two sources. The first is one of two ADC interrupt lines, chosen through a 2-bit interrupt-source field per slot. The second is the slot's regular trigger select, which names one of several external trigger lines. Software can also raise a request on any group of slots by writing a force word.

Each slot has a pending flag and an overflow flag. A trigger sets the pending flag. The flag drops when the sequencer reports, through a one-hot conversion-start vector, that the slot's conversion has begun. If a trigger arrives while the flag is still set and no conversion start clears it in that cycle, the overflow flag is set. Software clears overflow flags by writing ones to them. Arbitration between pending slots is left to the sequencer; this block only presents the pending and overflow vectors.

Top module: `conv_slot_tracker`

## Requirements
- R1: After reset every pending flag, every overflow flag and every interrupt-source field is 0, and the lines' edge history is cleared.
- R2: With interrupt-source value 00, a slot whose regular select is k (k > 0) is triggered by a rising edge on external line k-1, and a regular select of 0 never triggers it; pending bits rise only after a trigger or force.
- R3: Interrupt-source value 01 triggers the slot from a rising edge on interrupt line 1 (bit 0 of the interrupt input), and 10 triggers it from interrupt line 2 (bit 1). In both cases the regular select is ignored.
- R4: A slot whose interrupt-source value is 11 is never triggered by hardware. Only a force write can set it.
- R5: A trigger line counts once per rising edge. A line held high for several cycles sets a slot only in its first high cycle.
- R6: Writing address 2 sets the pending flag of every slot whose data bit is 1, one cycle later. Reading address 2 returns 0.
- R7: A conversion-start bit with no set request for that slot clears its pending flag on the next clock edge. The conversion-start input is one-hot or zero.
- R8: When a slot gets a set request and a clear in the same cycle, it ends up pending and hardware leaves its overflow flag unchanged.
- R9: A set request on a slot that is already pending, with no clear in that cycle, sets the slot's overflow flag.
- R10: Writing address 1 clears every overflow flag whose data bit is 1. A hardware overflow set in the same cycle wins over that clear.
- R11: Register reads are combinational on the address. Address 0 returns the pending vector, 1 the overflow vector, 3 the interrupt-source fields of slots 0 to 7, and 4 those of slots 8 to 15 (slot n in bits 2n+1:2n of its word). Every other address returns 0. Writes to address 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adc_int_i | input | 2 | ADC interrupt lines 1 and 2 |
| ext_trig_i | input | NUM_EXT (7) | External trigger lines |
| slot_tsel_i | input | NUM_SLOTS*TSEL_W (48) | Regular trigger select per slot, slot n in bits TSEL_W*n upward |
| conv_start_i | input | NUM_SLOTS (16) | One-hot conversion-start notice from the sequencer |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W (3) | Register address |
| bus_wdata_i | input | DATA_W (16) | Write data |
| bus_rdata_o | output | DATA_W (16) | Read data for bus_addr_i |
| pend_o | output | NUM_SLOTS (16) | Pending flags |
| ovf_o | output | NUM_SLOTS (16) | Overflow flags |

## Verification
The assertions assume that the sequencer never reports more than one conversion start per cycle. The checker states this as a property of its own, and the bench keeps its random start vector either zero or a single shifted bit. They also assume that lines are quiet while reset is held, so the edge history and the flags start together; the bench holds every input at zero until the internal reset has been released. Trigger lines are driven as sparse random pulses, some of them held, and the interrupt-source fields are rewritten now and then. In this way the value 11, the contention cases and the overflow cases all occur under random stimulus.

// File: rtl/tracker_pkg.sv
package tracker_pkg;
  localparam int ISRC_W  = 2;
  localparam int A_PEND  = 0;
  localparam int A_OVF   = 1;
  localparam int A_FORCE = 2;
  localparam int A_ISRC0 = 3;

  typedef enum logic [ISRC_W-1:0] {
    ISRC_REGULAR = 2'b00,
    ISRC_LINE1   = 2'b01,
    ISRC_LINE2   = 2'b10,
    ISRC_BAD     = 2'b11
  } isrc_e;
endpackage

// File: rtl/trig_edge.sv
module trig_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_nxt;

  always_comb begin
    prev_nxt = lvl_i;
    evt_o    = lvl_i & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_nxt;
  end
endmodule

// File: rtl/slot_src_sel.sv
module slot_src_sel
  import tracker_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int TSEL_W    = 3,
  parameter int NUM_EXT   = 7
) (
  input  logic [NUM_SLOTS*ISRC_W-1:0] isrc_i,
  input  logic [NUM_SLOTS*TSEL_W-1:0] tsel_i,
  input  logic [1:0]                  int_evt_i,
  input  logic [NUM_EXT-1:0]          ext_evt_i,
  output logic [NUM_SLOTS-1:0]        hw_set_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [TSEL_W-1:0] ts;
    isrc_e             sel;
    logic              reg_hit;

    always_comb begin
      ts      = tsel_i[s*TSEL_W +: TSEL_W];
      sel     = isrc_e'(isrc_i[s*ISRC_W +: ISRC_W]);
      reg_hit = 1'b0;
      for (int e = 0; e < NUM_EXT; e++) begin
        if (ts == TSEL_W'(e + 1)) reg_hit = ext_evt_i[e];
      end
      case (sel)
        ISRC_REGULAR: hw_set_o[s] = reg_hit;
        ISRC_LINE1:   hw_set_o[s] = int_evt_i[0];
        ISRC_LINE2:   hw_set_o[s] = int_evt_i[1];
        default:      hw_set_o[s] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/slot_flag_bank.sv
module slot_flag_bank #(
  parameter int NUM_SLOTS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] set_i,
  input  logic [NUM_SLOTS-1:0] clr_i,
  input  logic [NUM_SLOTS-1:0] ovf_clr_i,
  output logic [NUM_SLOTS-1:0] pend_o,
  output logic [NUM_SLOTS-1:0] ovf_o
);
  logic [NUM_SLOTS-1:0] pend_q, pend_nxt;
  logic [NUM_SLOTS-1:0] ovf_q, ovf_nxt, ovf_set;
  logic                 pend_en, ovf_en;

  always_comb begin
    // set dominates clear; contention never raises overflow
    pend_nxt = set_i | (pend_q & ~clr_i);
    ovf_set  = set_i & pend_q & ~clr_i;
    ovf_nxt  = ovf_set | (ovf_q & ~ovf_clr_i);
    pend_en  = |(set_i | clr_i);
    ovf_en   = |(ovf_set | ovf_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= '0;
    else if (ovf_en) ovf_q <= ovf_nxt;
  end

  assign pend_o = pend_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/tracker_regs.sv
module tracker_regs
  import tracker_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [NUM_SLOTS-1:0]        pend_i,
  input  logic [NUM_SLOTS-1:0]        ovf_i,
  output logic [NUM_SLOTS*ISRC_W-1:0] isrc_o,
  output logic [NUM_SLOTS-1:0]        force_o,
  output logic [NUM_SLOTS-1:0]        ovf_clr_o,
  output logic [DATA_W-1:0]           rdata_o
);
  localparam int SLOTS_PER_WORD = DATA_W / ISRC_W;
  localparam int ISRC_WORDS     = (NUM_SLOTS + SLOTS_PER_WORD - 1) / SLOTS_PER_WORD;
  localparam int ISRC_BITS      = ISRC_WORDS * DATA_W;

  logic [ISRC_BITS-1:0] isrc_q, isrc_nxt;
  logic                 isrc_en;
  logic                 wr_force, wr_ovf;

  always_comb begin
    wr_force  = wr_i && (addr_i == ADDR_W'(A_FORCE));
    wr_ovf    = wr_i && (addr_i == ADDR_W'(A_OVF));
    force_o   = wr_force ? wdata_i[NUM_SLOTS-1:0] : '0;
    ovf_clr_o = wr_ovf   ? wdata_i[NUM_SLOTS-1:0] : '0;
  end

  always_comb begin
    isrc_nxt = isrc_q;
    isrc_en  = 1'b0;
    for (int w = 0; w < ISRC_WORDS; w++) begin
      if (wr_i && (addr_i == ADDR_W'(A_ISRC0 + w))) begin
        isrc_nxt[w*DATA_W +: DATA_W] = wdata_i;
        isrc_en                      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       isrc_q <= '0;
    else if (isrc_en) isrc_q <= isrc_nxt;
  end

  assign isrc_o = isrc_q[NUM_SLOTS*ISRC_W-1:0];

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_PEND)) rdata_o = DATA_W'(pend_i);
    if (addr_i == ADDR_W'(A_OVF))  rdata_o = DATA_W'(ovf_i);
    for (int w = 0; w < ISRC_WORDS; w++) begin
      if (addr_i == ADDR_W'(A_ISRC0 + w)) rdata_o = isrc_q[w*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/conv_slot_tracker.sv
module conv_slot_tracker
  import tracker_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int TSEL_W    = 3,
  parameter int NUM_EXT   = 7,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  adc_int_i,
  input  logic [NUM_EXT-1:0]          ext_trig_i,
  input  logic [NUM_SLOTS*TSEL_W-1:0] slot_tsel_i,
  input  logic [NUM_SLOTS-1:0]        conv_start_i,
  input  logic                        bus_wr_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [DATA_W-1:0]           bus_wdata_i,
  output logic [DATA_W-1:0]           bus_rdata_o,
  output logic [NUM_SLOTS-1:0]        pend_o,
  output logic [NUM_SLOTS-1:0]        ovf_o
);
  logic [1:0]                  rst_sync_q;
  logic                        rst_s;
  logic [1:0]                  int_evt;
  logic [NUM_EXT-1:0]          ext_evt;
  logic [NUM_SLOTS*ISRC_W-1:0] isrc;
  logic [NUM_SLOTS-1:0]        hw_set, force_set, set_req, ovf_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  trig_edge #(.W(2)) u_int_edge (
    .clk(clk), .rst_n(rst_s), .lvl_i(adc_int_i), .evt_o(int_evt)
  );

  trig_edge #(.W(NUM_EXT)) u_ext_edge (
    .clk(clk), .rst_n(rst_s), .lvl_i(ext_trig_i), .evt_o(ext_evt)
  );

  slot_src_sel #(.NUM_SLOTS(NUM_SLOTS), .TSEL_W(TSEL_W), .NUM_EXT(NUM_EXT)) u_sel (
    .isrc_i(isrc), .tsel_i(slot_tsel_i), .int_evt_i(int_evt),
    .ext_evt_i(ext_evt), .hw_set_o(hw_set)
  );

  assign set_req = hw_set | force_set;

  slot_flag_bank #(.NUM_SLOTS(NUM_SLOTS)) u_flags (
    .clk(clk), .rst_n(rst_s), .set_i(set_req), .clr_i(conv_start_i),
    .ovf_clr_i(ovf_clr), .pend_o(pend_o), .ovf_o(ovf_o)
  );

  tracker_regs #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .pend_i(pend_o), .ovf_i(ovf_o), .isrc_o(isrc),
    .force_o(force_set), .ovf_clr_o(ovf_clr), .rdata_o(bus_rdata_o)
  );
endmodule

// File: rtl/conv_slot_tracker_chk.sv
module conv_slot_tracker_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3
) (
  input logic                 clk,
  input logic                 rst_s,
  input logic [NUM_SLOTS-1:0] pend_o,
  input logic [NUM_SLOTS-1:0] ovf_o,
  input logic [NUM_SLOTS-1:0] conv_start_i,
  input logic [NUM_SLOTS-1:0] set_req,
  input logic                 bus_wr_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [DATA_W-1:0]    bus_wdata_i
);
  always @(posedge clk) begin
    if (!rst_s) begin
      a_r1_reset_clear: assert (pend_o == '0 && ovf_o == '0)
        else $error("R1 flags not clear in reset");
    end
  end

  a_r2_rise_needs_trigger: assert property (@(posedge clk) disable iff (!rst_s)
    (pend_o & ~$past(pend_o) & ~$past(set_req)) == '0);

  a_r6_force_sets: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_wr_i && bus_addr_i == ADDR_W'(2)) |=>
      ((pend_o & $past(bus_wdata_i[NUM_SLOTS-1:0])) == $past(bus_wdata_i[NUM_SLOTS-1:0])));

  a_r7_start_onehot: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(conv_start_i));

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_s)
    ((conv_start_i & ~set_req) != '0) |=> ((pend_o & $past(conv_start_i & ~set_req)) == '0));

  a_r8_contention_pending: assert property (@(posedge clk) disable iff (!rst_s)
    ((conv_start_i & set_req) != '0) |=>
      ((pend_o & $past(conv_start_i & set_req)) == $past(conv_start_i & set_req)));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_s)
    ((conv_start_i & set_req) != '0) |=>
      ((ovf_o & ~$past(ovf_o) & $past(conv_start_i & set_req)) == '0));

  a_r9_overflow_set: assert property (@(posedge clk) disable iff (!rst_s)
    ((set_req & pend_o & ~conv_start_i) != '0) |=>
      ((ovf_o & $past(set_req & pend_o & ~conv_start_i)) == $past(set_req & pend_o & ~conv_start_i)));
endmodule

bind conv_slot_tracker conv_slot_tracker_chk #(
  .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_s(rst_s), .pend_o(pend_o), .ovf_o(ovf_o),
  .conv_start_i(conv_start_i), .set_req(set_req), .bus_wr_i(bus_wr_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i)
);

// File: tb/conv_slot_tracker_test.sv
module conv_slot_tracker_test;
  localparam int NS = 16;
  localparam int TW = 3;
  localparam int NE = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    adc_int;
  logic [NE-1:0] ext_trig;
  logic [NS*TW-1:0] tsel;
  logic [NS-1:0] conv_start;
  logic          bus_wr;
  logic [2:0]    bus_addr;
  logic [15:0]   bus_wdata, bus_rdata;
  logic [NS-1:0] pend, ovf;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // model state
  logic [NS-1:0]   m_pend, m_ovf;
  logic [2*NS-1:0] m_isrc;
  logic [1:0]      m_pint;
  logic [NE-1:0]   m_pext;

  always #5 clk = ~clk;

  conv_slot_tracker uut (
    .clk(clk), .rst_n(rst_n), .adc_int_i(adc_int), .ext_trig_i(ext_trig),
    .slot_tsel_i(tsel), .conv_start_i(conv_start), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pend_o(pend), .ovf_o(ovf)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rdata(logic [2:0] a);
    case (a)
      3'd0: return m_pend;
      3'd1: return m_ovf;
      3'd3: return m_isrc[15:0];
      3'd4: return m_isrc[31:16];
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [NS-1:0] exp_set();
    logic [1:0]    iev = adc_int & ~m_pint;
    logic [NE-1:0] eev = ext_trig & ~m_pext;
    logic [NS-1:0] s = '0;
    for (int k = 0; k < NS; k++) begin
      logic [TW-1:0] t = tsel[k*TW +: TW];
      case (m_isrc[2*k +: 2])
        2'b00: s[k] = (t != 0) && eev[t-1];
        2'b01: s[k] = iev[0];
        2'b10: s[k] = iev[1];
        default: s[k] = 1'b0;
      endcase
    end
    if (bus_wr && bus_addr == 3'd2) s |= bus_wdata;
    return s;
  endfunction

  task automatic idle();
    adc_int = '0; ext_trig = '0; conv_start = '0;
    bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = '0;
  endtask

  // inputs are set by caller just after a negedge
  task automatic step(string tag);
    logic [NS-1:0] s, c, oc;
    #1;
    check("R11 rdata", bus_rdata, exp_rdata(bus_addr));
    s  = exp_set();
    c  = conv_start;
    oc = (bus_wr && bus_addr == 3'd1) ? bus_wdata : '0;
    m_ovf  = (s & m_pend & ~c) | (m_ovf & ~oc);
    m_pend = s | (m_pend & ~c);
    if (bus_wr && bus_addr == 3'd3) m_isrc[15:0]  = bus_wdata;
    if (bus_wr && bus_addr == 3'd4) m_isrc[31:16] = bus_wdata;
    m_pint = adc_int;
    m_pext = ext_trig;
    @(posedge clk);
    @(negedge clk);
    check({tag, " pend"}, pend, m_pend);
    check({tag, " ovf"}, ovf, m_ovf);
  endtask

  task automatic bus_write(logic [2:0] a, logic [15:0] d, string tag);
    idle(); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step(tag);
    idle();
  endtask

  task automatic drain(string tag);
    for (int k = 0; k < NS; k++) begin
      idle(); conv_start = NS'(1) << k; step(tag);
    end
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
    rst_n = 1'b0;
    idle();
    for (int k = 0; k < NS; k++) tsel[k*TW +: TW] = TW'(k % 8);
    m_pend = '0; m_ovf = '0; m_isrc = '0; m_pint = '0; m_pext = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, including source fields
    check("R1 pend", pend, 16'h0);
    check("R1 ovf", ovf, 16'h0);
    bus_addr = 3'd3; #1; check("R1 isrc lo", bus_rdata, 16'h0);
    bus_addr = 3'd4; #1; check("R1 isrc hi", bus_rdata, 16'h0);
    idle(); step("R1");

    // R2 external line 2 hits slots with select 3 (slots 3, 11)
    idle(); ext_trig = 7'b0000100; step("R2");
    check("R2 slots 3 and 11", pend, 16'h0808);
    idle(); step("R2");
    // R7 clear slot 3 only
    idle(); conv_start = 16'h0008; step("R7");
    check("R7 slot 3 cleared", pend, 16'h0800);
    drain("R7");

    // R3 / R4: slot1=line1, slot2=line2, slot5=invalid
    bus_write(3'd3, 16'h0C24, "R3");
    idle(); adc_int = 2'b01; ext_trig = 7'b0000001; step("R3");
    check("R3 line1 slot1, ext0 slot9 only", pend, 16'h0202);
    idle(); adc_int = 2'b10; step("R3");
    check("R3 line2 slot2", pend, 16'h0206);
    drain("R3");
    idle(); adc_int = 2'b11; ext_trig = 7'h7f; step("R4");
    check("R4 slot5 untouched", pend[5], 1'b0);
    drain("R4");

    // R5 held line counts once
    idle(); ext_trig = 7'b0010000; step("R5");
    ext_trig = 7'b0010000; conv_start = 16'h0020; step("R5");
    check("R5 slot13 still pending", pend, 16'h2000);
    ext_trig = 7'b0010000; step("R5");
    ext_trig = 7'b0010000; conv_start = 16'h2000; step("R5");
    ext_trig = 7'b0010000; step("R5");
    check("R5 held line no retrigger", pend, 16'h0000);
    drain("R5");

    // R6 force write, read returns 0
    idle(); bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 16'hA5A5; step("R6");
    check("R6 forced", pend, 16'hA5A5);
    idle(); bus_addr = 3'd2; #1; check("R6 read zero", bus_rdata, 16'h0);

    // R8 contention: slot0 pending, force and start together
    idle(); bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 16'h0001; conv_start = 16'h0001;
    step("R8");
    check("R8 still pending", pend[0], 1'b1);
    check("R8 no overflow", ovf[0], 1'b0);

    // R9 set on pending slot 7 without clear
    bus_write(3'd2, 16'h0080, "R9");
    check("R9 overflow slot7", ovf, 16'h0080);

    // R10 w1c; then line1 overflow on slot1 wins over clear
    bus_write(3'd2, 16'h0002, "R10");
    bus_write(3'd1, 16'h0080, "R10");
    check("R10 cleared", ovf, 16'h0000);
    idle(); adc_int = 2'b01; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 16'h0002; step("R10");
    check("R10 set wins", ovf[1], 1'b1);

    // R11 write to pending address ignored
    bus_write(3'd0, 16'hFFFF, "R11");
    check("R11 pend unchanged by write", pend, 16'hA5A7);
    drain("R11");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle();
      adc_int  = 2'($urandom_range(0, 3) & ($urandom_range(0, 3) == 0 ? 3 : 0));
      ext_trig = 7'($urandom) & 7'($urandom) & 7'($urandom);
      r = $urandom_range(0, 2 * NS - 1);
      if (r < NS) conv_start = NS'(1) << r;
      if ($urandom_range(0, 3) == 0) begin
        bus_wr    = 1'b1;
        bus_addr  = 3'($urandom_range(0, 6));
        bus_wdata = 16'($urandom) & 16'($urandom);
        if (bus_addr == 3'd3 || bus_addr == 3'd4) bus_wdata = 16'($urandom);
      end else begin
        bus_addr = 3'($urandom_range(0, 6));
      end
      if (n % 500 == 0)
        for (int k = 0; k < NS; k++) tsel[k*TW +: TW] = TW'($urandom);
      step("R9 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule